// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the lowest layer of an I2C master. It drives the open-drain SCL and SDA lines as pull-down enables, reads both lines back, and carries out one bus primitive per command: a start condition, a repeated start, a stop condition, an 8-bit write that samples the acknowledge bit, an 8-bit read, or a single acknowledge or not-acknowledge clock. Address formatting, message sequencing and arbitration belong to the controller above it.

Every rising SCL edge is a handshake. The engine releases SCL, waits until the line reads high (a target may stretch the clock), and gives up after a programmable number of low samples. The last sample before giving up still counts, so a line that goes high on the final cycle is accepted. One delay value `cfg_delay` (D) sets the pace. After SCL is confirmed high the engine waits D. After it pulls SCL low it waits floor(D/2). After it changes SDA it waits ceil(D/2). The start and repeated-start hold, and the stop settle, are a full D.

The controller hands over a command with a valid/ready handshake. A one-cycle `done` pulse carries the outcome: ok, ack, nak or timeout. A read also returns the received byte.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both pull enables are low, `cmd_ready` is high and `done` is low.
- R2: Command START (op 0) pulls SDA low for D+1 cycles with SCL released, then pulls SCL low for floor(D/2)+1 cycles, then signals done with status ok (0).
- R3: Command RESTART (op 1) releases SDA for ceil(D/2)+1 cycles, raises SCL with the stretch wait and then holds it D+1 cycles, pulls SDA low for D+1 cycles, pulls SCL low for floor(D/2)+1 cycles, and then finishes with status ok.
- R4: Command STOP (op 2) pulls SDA low for ceil(D/2)+1 cycles, raises SCL with the stretch wait and then holds it D+1 cycles, releases SDA for D+1 cycles, and then finishes with status ok.
- R5: Command WRITE (op 3) sends `cmd_wdata` MSB first and then gives a ninth clock with SDA released. Each bit sets SDA for ceil(D/2)+1 cycles, raises SCL and holds it, then pulls SCL low for floor(D/2)+1 cycles. SDA is sampled in the last cycle of the ninth high phase: low gives status ack (1), high gives status nak (2).
- R6: Command READ (op 4) releases SDA for ceil(D/2)+1 cycles and then takes 8 clocks, sampling SDA MSB first in the last high cycle of each. SCL then stays low for D+1 cycles after bits 1 to 7 and for floor(D/2)+1 cycles after bit 8. `rdata` holds the byte when done is pulsed.
- R7: Command ACKNAK (op 5) pulls SDA low only when `cmd_ack` is 1, waits ceil(D/2)+1 cycles, gives one SCL clock with the stretch wait, and then finishes with status ok.
- R8: The delay split holds for even, odd and zero D. Each step lasts its wait count plus one cycle.
- R9: When SCL sensing is enabled, the engine waits in the released state one cycle per low sample of `scl_in` and leaves on the first high sample. A high sample in the expiry cycle (after `cfg_timeout` low samples) is still accepted.
- R10: If `scl_in` is still low in the expiry cycle, the command aborts. The engine pulses done with status timeout (3) in the next cycle, with SCL left released.
- R11: With `cfg_sense` low the engine ignores `scl_in`. Each SCL rise takes one cycle followed by the D+1 cycle hold.
- R12: `cmd_ready` is high only while idle. A command is accepted on a clock with `cmd_valid` and `cmd_ready` both high. `done` is a single-cycle pulse that coincides with `cmd_ready` returning high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted this cycle if valid |
| cmd_op | input | 3 | 0 START, 1 RESTART, 2 STOP, 3 WRITE, 4 READ, 5 ACKNAK |
| cmd_wdata | input | 8 | Byte for WRITE |
| cmd_ack | input | 1 | For ACKNAK: 1 sends ACK, 0 sends NAK |
| cfg_delay | input | DLY_W | Full delay D in clock cycles |
| cfg_timeout | input | TMO_W | Low samples of SCL tolerated before timeout |
| cfg_sense | input | 1 | SCL read-back available |
| scl_in | input | 1 | Sensed SCL line |
| sda_in | input | 1 | Sensed SDA line |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |
| done | output | 1 | Command finished (one cycle) |
| status | output | 2 | 0 ok, 1 ack, 2 nak, 3 timeout |
| rdata | output | 8 | Byte received by READ |

## Verification
On every cycle, the in-line assertions check the following:
- A timeout is reported only after a low SCL sample with sensing enabled.
- SCL is held only after a high sample, or with sensing disabled.
- SDA never changes while SCL is held high.
- `done` is a single pulse that lands in the idle state.
- An accepted command makes the engine busy.

The exact length of each step, the MSB-first bit order, the acknowledge decode, the asymmetric half delays for odd and zero D, and the boundary where the stretch ends exactly at expiry can only be shown by the bench's scenarios. In those scenarios, a behavioural timeline is compared with both pull enables and the handshake on every clock.

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int DLY_W = 8,
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_wdata,
  input  logic             cmd_ack,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [TMO_W-1:0] cfg_timeout,
  input  logic             cfg_sense,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             done,
  output logic [1:0]       status,
  output logic [7:0]       rdata
);
  localparam logic [2:0] OP_START = 3'd0, OP_RESTART = 3'd1, OP_STOP = 3'd2,
                         OP_WRITE = 3'd3, OP_READ = 3'd4, OP_ACKNAK = 3'd5;
  localparam logic [1:0] ST_OK = 2'd0, ST_ACK = 2'd1, ST_NAK = 2'd2, ST_TMO = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_SDA, S_RISE, S_HIGH, S_LOW, S_GAP} state_t;

  state_t           state;
  logic [2:0]       op;
  logic [DLY_W-1:0] cnt;
  logic [TMO_W-1:0] tcnt;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic             ackbit;

  wire [DLY_W-1:0] d_full = cfg_delay;
  wire [DLY_W-1:0] d_dn   = cfg_delay >> 1;
  wire [DLY_W-1:0] d_up   = cfg_delay - d_dn;
  wire             cnt_zero = (cnt == '0);

  assign cmd_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op       <= OP_START;
      cnt      <= '0;
      tcnt     <= '0;
      bitcnt   <= '0;
      shreg    <= '0;
      ackbit   <= 1'b0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      done     <= 1'b0;
      status   <= ST_OK;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          op     <= cmd_op;
          bitcnt <= '0;
          case (cmd_op)
            OP_START: begin
              sda_pull <= 1'b1; cnt <= d_full; state <= S_GAP;
            end
            OP_RESTART, OP_STOP: begin
              sda_pull <= (cmd_op == OP_STOP); cnt <= d_up; state <= S_SDA;
            end
            OP_WRITE: begin
              sda_pull <= !cmd_wdata[7];
              shreg    <= {cmd_wdata[6:0], 1'b0};
              cnt      <= d_up; state <= S_SDA;
            end
            OP_READ: begin
              sda_pull <= 1'b0; cnt <= d_up; state <= S_SDA;
            end
            OP_ACKNAK: begin
              sda_pull <= cmd_ack; cnt <= d_up; state <= S_SDA;
            end
            default: begin
              done <= 1'b1; status <= ST_OK;
            end
          endcase
        end
        S_SDA: begin
          if (cnt_zero) begin
            scl_pull <= 1'b0; tcnt <= '0; state <= S_RISE;
          end else cnt <= cnt - 1'b1;
        end
        S_RISE: begin
          if (!cfg_sense || scl_in) begin
            cnt <= d_full; state <= S_HIGH;
          end else if (tcnt == cfg_timeout) begin
            state <= S_IDLE; done <= 1'b1; status <= ST_TMO;
          end else tcnt <= tcnt + 1'b1;
        end
        S_HIGH: begin
          if (cnt_zero) begin
            bitcnt <= bitcnt + 1'b1;
            if (op == OP_WRITE && bitcnt == 4'd8) ackbit <= !sda_in;
            if (op == OP_READ) rdata <= {rdata[6:0], sda_in};
            if (op == OP_RESTART || op == OP_STOP) begin
              sda_pull <= (op == OP_RESTART); cnt <= d_full; state <= S_GAP;
            end else begin
              scl_pull <= 1'b1;
              cnt      <= (op == OP_READ && bitcnt != 4'd7) ? d_full : d_dn;
              state    <= S_LOW;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_LOW: begin
          if (cnt_zero) begin
            if (op == OP_WRITE) begin
              if (bitcnt == 4'd9) begin
                state <= S_IDLE; done <= 1'b1; status <= ackbit ? ST_ACK : ST_NAK;
              end else if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0; cnt <= d_up; state <= S_SDA;
              end else begin
                sda_pull <= !shreg[7]; shreg <= {shreg[6:0], 1'b0};
                cnt <= d_up; state <= S_SDA;
              end
            end else if (op == OP_READ && bitcnt != 4'd8) begin
              scl_pull <= 1'b0; tcnt <= '0; state <= S_RISE;
            end else begin
              state <= S_IDLE; done <= 1'b1; status <= ST_OK;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_GAP: begin
          if (cnt_zero) begin
            if (op == OP_STOP) begin
              state <= S_IDLE; done <= 1'b1; status <= ST_OK;
            end else begin
              scl_pull <= 1'b1; cnt <= d_dn; state <= S_LOW;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  tmo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_TMO) |-> $past(!scl_in && cfg_sense));

  // R9
  rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGH && $past(state) == S_RISE) |-> $past(scl_in || !cfg_sense));

  // R5
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGH && $past(state) == S_HIGH) |-> $stable(sda_pull));

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !$past(done)));

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op <= OP_ACKNAK) |=> !cmd_ready);
endmodule

// File: tb/test_i2c_bit_engine.sv
module test_i2c_bit_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cmd_valid = 1'b0, cmd_ack = 1'b0, cfg_sense = 1'b1;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] cfg_delay = 8'd4;
  logic [11:0] cfg_timeout = 12'd6;
  logic       cmd_ready, scl_pull, sda_pull, done, scl_in, sda_in;
  logic [1:0] status;
  logic [7:0] rdata;

  i2c_bit_engine i_i2c_bit_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
    .cfg_delay(cfg_delay), .cfg_timeout(cfg_timeout), .cfg_sense(cfg_sense),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .done(done), .status(status), .rdata(rdata));

  // bus target model
  int   stretch = 0, scnt = 0, falls = 0, idx_base = 0, mode = 0;
  logic slave_ack = 1'b1, prev_scl = 1'b0, slave_pull;
  logic [7:0] slave_byte = '0;
  int idx;
  always @(posedge clk) begin
    scnt <= scl_pull ? 0 : (scnt < 100000 ? scnt + 1 : scnt);
    prev_scl <= scl_pull;
    if (scl_pull && !prev_scl) falls <= falls + 1;
  end
  assign idx = falls - idx_base;
  always_comb begin
    slave_pull = 1'b0;
    if (mode == 1 && idx == 8 && slave_ack) slave_pull = 1'b1;
    if (mode == 2 && idx >= 0 && idx < 8) slave_pull = !slave_byte[7 - idx];
  end
  assign scl_in = !scl_pull && (scnt >= stretch);
  assign sda_in = !sda_pull && !slave_pull;

  int tests = 0, fails = 0;
  logic [3:0] exq[$];
  logic cur_scl = 1'b0, cur_sda = 1'b0;
  logic tmo;

  task automatic push(int n);
    for (int k = 0; k < n; k++) exq.push_back({cur_scl, cur_sda, 2'b00});
  endtask
  task automatic m_sda(logic v, int n); cur_sda = v; push(n + 1); endtask
  task automatic m_low(int n); cur_scl = 1'b1; push(n + 1); endtask
  task automatic m_rise();
    int d = cfg_delay;
    cur_scl = 1'b0;
    if (!cfg_sense) push(1);
    else if (stretch <= cfg_timeout) push(stretch + 1);
    else begin push(int'(cfg_timeout) + 1); tmo = 1'b1; return; end
    push(d + 1);
  endtask

  task automatic run(logic [2:0] op, logic [7:0] wd, logic ak, string tag,
                     logic [1:0] exp_st, logic chk_rd, logic [7:0] exp_rd);
    int d = cfg_delay, h = cfg_delay, lo = cfg_delay / 2, up = (cfg_delay + 1) / 2;
    logic [1:0] est = exp_st;
    int n;
    tmo = 1'b0;
    exq.delete();
    case (op)
      3'd0: begin m_sda(1'b1, h); m_low(lo); end
      3'd1: begin m_sda(1'b0, up); m_rise();
                  if (!tmo) begin m_sda(1'b1, h); m_low(lo); end end
      3'd2: begin m_sda(1'b1, up); m_rise(); if (!tmo) m_sda(1'b0, h); end
      3'd3: begin
        for (int b = 7; b >= 0 && !tmo; b--) begin
          m_sda(!wd[b], up); m_rise(); if (!tmo) m_low(lo);
        end
        if (!tmo) begin m_sda(1'b0, up); m_rise(); if (!tmo) m_low(lo); end
      end
      3'd4: begin
        m_sda(1'b0, up);
        for (int b = 0; b < 8 && !tmo; b++) begin
          m_rise(); if (!tmo) m_low(b == 7 ? lo : h);
        end
      end
      default: begin m_sda(ak, up); m_rise(); if (!tmo) m_low(lo); end
    endcase
    if (tmo) est = 2'd3;
    exq.push_back({cur_scl, cur_sda, 2'b11});
    @(negedge clk);
    tests++;
    if (!cmd_ready) begin fails++; $display("FAIL R12 ready before %s: got 0 exp 1", tag); end
    cmd_op = op; cmd_wdata = wd; cmd_ack = ak; cmd_valid = 1'b1; idx_base = falls;
    @(posedge clk);
    n = exq.size();
    for (int k = 0; k < n; k++) begin
      logic [3:0] e = exq.pop_front();
      @(negedge clk);
      cmd_valid = 1'b0;
      tests++;
      if (scl_pull !== e[3] || sda_pull !== e[2]) begin
        fails++;
        $display("FAIL %s cycle %0d lines: got scl=%b sda=%b exp scl=%b sda=%b",
                 tag, k, scl_pull, sda_pull, e[3], e[2]);
      end
      tests++;
      if (done !== e[1] || cmd_ready !== e[0]) begin
        fails++;
        $display("FAIL R12 (%s) cycle %0d handshake: got done=%b ready=%b exp done=%b ready=%b",
                 tag, k, done, cmd_ready, e[1], e[0]);
      end
      if (e[1]) begin
        tests++;
        if (status !== est) begin
          fails++; $display("FAIL %s status: got %0d exp %0d", tag, status, est);
        end
        if (chk_rd) begin
          tests++;
          if (rdata !== exp_rd) begin
            fails++; $display("FAIL %s rdata: got %h exp %h", tag, rdata, exp_rd);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no end exp end");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (scl_pull !== 1'b0 || sda_pull !== 1'b0 || cmd_ready !== 1'b1 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got scl=%b sda=%b ready=%b done=%b exp 0 0 1 0",
               scl_pull, sda_pull, cmd_ready, done);
    end
    // D=4, timeout 6, no stretch
    run(3'd0, 8'h00, 1'b0, "R2", 2'd0, 1'b0, 8'h00);
    mode = 1; slave_ack = 1'b1;
    run(3'd3, 8'hA5, 1'b0, "R5", 2'd1, 1'b0, 8'h00);
    slave_ack = 1'b0;
    run(3'd3, 8'h3C, 1'b0, "R5", 2'd2, 1'b0, 8'h00);
    mode = 0;
    run(3'd1, 8'h00, 1'b0, "R3", 2'd0, 1'b0, 8'h00);
    mode = 2; slave_byte = 8'hC6;
    run(3'd4, 8'h00, 1'b0, "R6", 2'd0, 1'b1, 8'hC6);
    mode = 0;
    run(3'd5, 8'h00, 1'b1, "R7", 2'd0, 1'b0, 8'h00);
    stretch = 3; mode = 2; slave_byte = 8'h5A;
    run(3'd4, 8'h00, 1'b0, "R9", 2'd0, 1'b1, 8'h5A);
    mode = 0;
    run(3'd5, 8'h00, 1'b0, "R7", 2'd0, 1'b0, 8'h00);
    stretch = 0;
    run(3'd2, 8'h00, 1'b0, "R4", 2'd0, 1'b0, 8'h00);
    // odd delay and stretch equal to the timeout
    cfg_delay = 8'd5;
    run(3'd0, 8'h00, 1'b0, "R8", 2'd0, 1'b0, 8'h00);
    stretch = 6; mode = 1; slave_ack = 1'b1;
    run(3'd3, 8'h96, 1'b0, "R9", 2'd1, 1'b0, 8'h00);
    stretch = 0; mode = 0;
    run(3'd2, 8'h00, 1'b0, "R8", 2'd0, 1'b0, 8'h00);
    // zero delay
    cfg_delay = 8'd0;
    run(3'd0, 8'h00, 1'b0, "R8", 2'd0, 1'b0, 8'h00);
    mode = 2; slave_byte = 8'h81;
    run(3'd4, 8'h00, 1'b0, "R8", 2'd0, 1'b1, 8'h81);
    mode = 0;
    run(3'd5, 8'h00, 1'b0, "R7", 2'd0, 1'b0, 8'h00);
    run(3'd2, 8'h00, 1'b0, "R4", 2'd0, 1'b0, 8'h00);
    // stretch beyond timeout
    cfg_delay = 8'd4;
    run(3'd0, 8'h00, 1'b0, "R2", 2'd0, 1'b0, 8'h00);
    stretch = 7;
    run(3'd3, 8'hFF, 1'b0, "R10", 2'd1, 1'b0, 8'h00);
    stretch = 0;
    run(3'd2, 8'h00, 1'b0, "R4", 2'd0, 1'b0, 8'h00);
    // sensing disabled while target holds the clock
    cfg_sense = 1'b0; stretch = 10;
    run(3'd0, 8'h00, 1'b0, "R11", 2'd0, 1'b0, 8'h00);
    mode = 1; slave_ack = 1'b1;
    run(3'd3, 8'h12, 1'b0, "R11", 2'd1, 1'b0, 8'h00);
    mode = 0;
    run(3'd2, 8'h00, 1'b0, "R11", 2'd0, 1'b0, 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule